// File: doc/BRIEF.md
# Windowed Dead-Man Timer

This block watches that software keeps making progress. A counter advances by one on each clock where the count-enable input is high, and software must hit a service strobe before the counter reaches a terminal count. The terminal count is a power of two picked by a 5-bit code. A 3-bit code sets how far into that span servicing becomes allowed. A service strobe that arrives too early is flagged as an error. Missing the deadline raises a timeout.

The timer runs whenever the configuration enable is high. When that enable is low, the software ON bit decides whether it runs. A stopped timer holds its counter at zero. Resets and the register that stores the codes are handled by surrounding logic. The block only reports one-cycle events and a level flag that shows when servicing is currently legal.

Top module: `dmt_windowed`

## Requirements
- R1: While reset is low, and on its release, the counter is zero and both events are low. With the timer running and any window code from 1 to 7, the window flag reads 0 because the count is zero.
- R2: The timer runs when the configuration enable is 1, whatever the ON bit is. When the enable is 0, the ON bit alone decides. A stopped timer clears its counter to zero, holds the window flag low, and ignores the service strobe: no event and no effect on the count.
- R3: While running, the counter rises by exactly one on each clock edge where count enable is 1. It holds its value on edges where count enable is 0.
- R4: A count select code n from 0 to 23 sets the terminal count T to 2^(n+8). On the edge where a running, enabled counter at T-1 would advance, the counter returns to zero. The timeout event is then high for exactly the following cycle.
- R5: Count select codes 24 to 31 behave exactly like code 23, so T = 2^31.
- R6: A window code k from 1 to 7 puts the opening point at T - T/2^k. While running, the window flag is 1 exactly when the count is at or above that point.
- R7: Window code 0 puts the opening point at zero. The window flag is then 1 whenever the timer runs, and a service is legal at any count.
- R8: A service strobe while running with the window flag at 1 is legal. The counter goes to zero on that edge and no timeout follows, even if the count was at T-1 with count enable high.
- R9: A service strobe while running with the window flag at 0 makes the service-error event high for exactly the following cycle. The counter carries on as though no strobe had arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Advance the counter on this edge |
| cnt_sel | input | 5 | Terminal count code |
| win_sel | input | 3 | Window opening code |
| cfg_en | input | 1 | Configuration enable; forces the timer on |
| sw_on | input | 1 | Software run bit, used when cfg_en is 0 |
| svc | input | 1 | Service strobe |
| tmo_evt | output | 1 | One-cycle timeout event |
| win_open | output | 1 | Service is legal now |
| svc_err | output | 1 | One-cycle early-service event |

## Verification
The counter is not visible at the ports, so a wrong count first appears on the window flag. Because that flag is combinational on the count register, it goes wrong in the same cycle the count diverges whenever the count is near the opening point. A divergence elsewhere shows up later as a timeout in the wrong cycle, or as an error instead of a legal service, one cycle after the edge concerned. The bench predicts every cycle's three outputs from the requirements and compares them on every cycle. A counter that is off by one edge is therefore caught at the window threshold or at the timeout, and never goes more than one terminal span unnoticed.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
   // one-cycle events produced by the counting core
   typedef struct packed {
      logic expired;
      logic early;
   } dmt_evt_t;

   localparam int DMT_CNT_W    = 32;
   localparam int DMT_SEL_W    = 5;
   localparam int DMT_WIN_W    = 3;
   localparam int DMT_BASE_EXP = 8;
   localparam int DMT_TOP_CODE = 23;
endpackage

// File: rtl/dmt_span_decode.sv
module dmt_span_decode #(
   parameter int CNT_W      = dmt_pkg::DMT_CNT_W,
   parameter int SEL_W      = dmt_pkg::DMT_SEL_W,
   parameter int WIN_W      = dmt_pkg::DMT_WIN_W,
   parameter int BASE_EXP   = dmt_pkg::DMT_BASE_EXP,
   parameter int TOP_CODE   = dmt_pkg::DMT_TOP_CODE,
   parameter bit RSV_TO_MAX = 1'b1
) (
   input  logic [SEL_W-1:0] cnt_sel,
   input  logic [WIN_W-1:0] win_sel,
   output logic [CNT_W-1:0] term_mask,
   output logic [CNT_W-1:0] open_at
);
   localparam int EXP_W = $clog2(CNT_W + 1);

   logic [SEL_W-1:0] eff_sel;
   logic [EXP_W-1:0] span_exp;

   // reserved codes: either pinned to the largest span or to the smallest
   generate
      if (RSV_TO_MAX) begin : g_rsv_max
         assign eff_sel = (cnt_sel > SEL_W'(TOP_CODE)) ? SEL_W'(TOP_CODE) : cnt_sel;
      end else begin : g_rsv_min
         assign eff_sel = (cnt_sel > SEL_W'(TOP_CODE)) ? '0 : cnt_sel;
      end
   endgenerate

   assign span_exp = EXP_W'(eff_sel) + EXP_W'(BASE_EXP);

   // term_mask = T-1: ones below the span exponent
   generate
      for (genvar b = 0; b < CNT_W; b++) begin : g_mask
         assign term_mask[b] = (int'(span_exp) > b);
      end
   endgenerate

   // T - T/2^k == (T-1) - ((T-1) >> k) for k <= exponent
   always_comb begin
      if (win_sel == '0) open_at = '0;
      else               open_at = term_mask - (term_mask >> win_sel);
   end
endmodule

// File: rtl/dmt_count_core.sv
module dmt_count_core #(
   parameter int CNT_W = dmt_pkg::DMT_CNT_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                adv,
   input  logic                svc,
   input  logic [CNT_W-1:0]    term_mask,
   input  logic [CNT_W-1:0]    open_at,
   output logic [CNT_W-1:0]    count_q,
   output logic                in_window,
   output dmt_pkg::dmt_evt_t   evt_next
);
   logic legal;
   logic wrap;

   always_comb begin
      in_window        = (count_q >= open_at);
      legal            = run & svc & in_window;
      evt_next.early   = run & svc & ~in_window;
      wrap             = run & adv & ~legal & (count_q >= term_mask);
      evt_next.expired = wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count_q <= '0;
      else if (!run || legal || wrap) count_q <= '0;
      else if (adv)                 count_q <= count_q + CNT_W'(1);
   end
endmodule

// File: rtl/dmt_event_reg.sv
module dmt_event_reg (
   input  logic              clk,
   input  logic              rst_n,
   input  dmt_pkg::dmt_evt_t evt_next,
   output logic              tmo_evt,
   output logic              svc_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_evt <= 1'b0;
         svc_err <= 1'b0;
      end else begin
         tmo_evt <= evt_next.expired;
         svc_err <= evt_next.early;
      end
   end
endmodule

// File: rtl/dmt_windowed.sv
module dmt_windowed #(
   parameter int CNT_W      = dmt_pkg::DMT_CNT_W,
   parameter int SEL_W      = dmt_pkg::DMT_SEL_W,
   parameter int WIN_W      = dmt_pkg::DMT_WIN_W,
   parameter int BASE_EXP   = dmt_pkg::DMT_BASE_EXP,
   parameter int TOP_CODE   = dmt_pkg::DMT_TOP_CODE,
   parameter bit RSV_TO_MAX = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   input  logic [SEL_W-1:0] cnt_sel,
   input  logic [WIN_W-1:0] win_sel,
   input  logic             cfg_en,
   input  logic             sw_on,
   input  logic             svc,
   output logic             tmo_evt,
   output logic             win_open,
   output logic             svc_err
);
   localparam int MAX_WIN_K = (1 << WIN_W) - 1;

   // elaboration-time parameter checks
   if (BASE_EXP + TOP_CODE >= CNT_W) begin : g_bad_span
      $error("largest terminal count does not fit the counter width");
   end
   if (MAX_WIN_K > BASE_EXP) begin : g_bad_win
      $error("window fraction finer than the smallest terminal count");
   end
   if (TOP_CODE >= (1 << SEL_W)) begin : g_bad_code
      $error("top count code does not fit the select width");
   end

   logic              run;
   logic [CNT_W-1:0]  term_mask;
   logic [CNT_W-1:0]  open_at;
   logic [CNT_W-1:0]  count_q;
   logic              in_window;
   dmt_pkg::dmt_evt_t evt_next;

   assign run = cfg_en | sw_on;

   dmt_span_decode #(
      .CNT_W(CNT_W), .SEL_W(SEL_W), .WIN_W(WIN_W),
      .BASE_EXP(BASE_EXP), .TOP_CODE(TOP_CODE), .RSV_TO_MAX(RSV_TO_MAX)
   ) u_decode (
      .cnt_sel  (cnt_sel),
      .win_sel  (win_sel),
      .term_mask(term_mask),
      .open_at  (open_at)
   );

   dmt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .adv      (count_en),
      .svc      (svc),
      .term_mask(term_mask),
      .open_at  (open_at),
      .count_q  (count_q),
      .in_window(in_window),
      .evt_next (evt_next)
   );

   dmt_event_reg u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_next(evt_next),
      .tmo_evt (tmo_evt),
      .svc_err (svc_err)
   );

   assign win_open = run & in_window;
endmodule

// File: rtl/dmt_windowed_chk.sv
module dmt_windowed_chk #(
   parameter int CNT_W = dmt_pkg::DMT_CNT_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_en,
   input logic             sw_on,
   input logic             count_en,
   input logic             svc,
   input logic             tmo_evt,
   input logic             svc_err,
   input logic             win_open,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] term_mask
);
   logic on_c;
   assign on_c = cfg_en | sw_on;

   // R2: a stopped timer raises no event on the next cycle
   p_stopped_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !on_c |=> (!tmo_evt && !svc_err));

   // R2: a stopped timer never opens the window
   p_stopped_shut_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !on_c |-> !win_open);

   // R3: a plain enabled edge below terminal adds one
   p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (on_c && count_en && !svc && count < term_mask) |=> count == $past(count) + CNT_W'(1));

   // R3: no count enable, no service: count holds
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (on_c && !count_en && !svc) |=> $stable(count));

   // R4: timeout is a single-cycle pulse
   p_tmo_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_evt |=> !tmo_evt);

   // R8: a legal service zeroes the count and suppresses timeout
   p_legal_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (on_c && svc && win_open) |=> (count == '0 && !tmo_evt && !svc_err));

   // R9: an error always traces back to an early strobe
   p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      svc_err |-> $past(on_c && svc && !win_open));
endmodule

bind dmt_windowed dmt_windowed_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_en   (cfg_en),
   .sw_on    (sw_on),
   .count_en (count_en),
   .svc      (svc),
   .tmo_evt  (tmo_evt),
   .svc_err  (svc_err),
   .win_open (win_open),
   .count    (count_q),
   .term_mask(term_mask)
);

// File: tb/dmt_windowed_test.sv
module dmt_windowed_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       count_en, cfg_en, sw_on, svc;
   logic [4:0] cnt_sel;
   logic [2:0] win_sel;
   logic       tmo_evt, win_open, svc_err;

   always #5 clk = ~clk;

   dmt_windowed uut (
      .clk(clk), .rst_n(rst_n), .count_en(count_en), .cnt_sel(cnt_sel),
      .win_sel(win_sel), .cfg_en(cfg_en), .sw_on(sw_on), .svc(svc),
      .tmo_evt(tmo_evt), .win_open(win_open), .svc_err(svc_err)
   );

   typedef struct {
      int    due;
      bit    tmo;
      bit    err;
      bit    win;
      string tag;
   } exp_t;

   exp_t   sb[$];
   int     cyc = 0;
   int     vecs = 0;
   int     bad = 0;
   bit     done = 0;
   longint m = 0;
   string  tag = "R1";
   bit     n_cfg = 0, n_on = 0;
   logic [4:0] n_sel = 0;
   logic [2:0] n_win = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string req, string what, longint got, longint want);
      vecs++;
      if (got != want) begin
         bad++;
         $display("FAIL %s %s got %0d expected %0d (cycle %0d)", req, what, got, want, cyc);
      end
   endtask

   // driver: applies one cycle of stimulus and predicts the outcome
   task automatic step(bit ce, bit s);
      exp_t   e;
      longint t, iv;
      int     n;
      bit     run;
      @(negedge clk);
      cfg_en = n_cfg; sw_on = n_on; cnt_sel = n_sel; win_sel = n_win;
      count_en = ce; svc = s;
      run = n_cfg | n_on;
      n   = (int'(n_sel) > 23) ? 23 : int'(n_sel);
      t   = longint'(1) << (n + 8);
      iv  = (n_win == 0) ? 0 : t - (t >> n_win);
      e.tmo = 0; e.err = 0; e.tag = tag; e.due = cyc + 1;
      if (!run) m = 0;
      else if (s && m >= iv) m = 0;
      else begin
         e.err = s;
         if (ce) begin
            if (m >= t - 1) begin m = 0; e.tmo = 1; end
            else m++;
         end
      end
      e.win = run && (m >= iv);
      sb.push_back(e);
   endtask

   // monitor: compares each predicted cycle once the design produces it
   always begin
      exp_t e;
      @(posedge clk);
      #4;
      if (rst_n === 1'b1 && sb.size() > 0 && sb[0].due == cyc) begin
         e = sb.pop_front();
         check(e.tag, "timeout", tmo_evt, e.tmo);
         check(e.tag, "service error", svc_err, e.err);
         check(e.tag, "window flag", win_open, e.win);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      vecs++; bad++;
      $display("FAIL watchdog expired before the end of the run");
      finish_run();
   end

   initial begin
      rst_n = 0; count_en = 0; cfg_en = 0; sw_on = 0; svc = 0;
      cnt_sel = 0; win_sel = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "timeout in reset", tmo_evt, 0);
      check("R1", "service error in reset", svc_err, 0);
      cfg_en = 1; win_sel = 3'd1; count_en = 1;
      #1;
      check("R1", "window flag at zero count", win_open, 0);
      cfg_en = 0; count_en = 0; win_sel = 0;
      @(negedge clk);
      rst_n = 1;
      m = 0;

      // R2: stopped timer ignores service
      tag = "R2"; n_cfg = 0; n_on = 0; n_sel = 0; n_win = 1;
      repeat (5) step(1, 0);
      step(1, 1); step(1, 0);

      // R3 and R9: counting, holding, early service
      tag = "R3"; n_cfg = 1; n_on = 0;
      repeat (40) step(1, 0);
      repeat (10) step(0, 0);
      tag = "R9"; step(1, 1); step(0, 1);
      repeat (20) step(1, 0);

      // R6 then R8: window opens at 128 of 256, legal service clears
      tag = "R6"; while (m < 130) step(1, 0);
      tag = "R8"; step(1, 1);
      // R4: free run to a timeout
      tag = "R4"; repeat (300) step(1, 0);
      // R8: service at T-1 with count enable beats the timeout
      tag = "R8"; while (m != 255) step(1, 0);
      step(1, 1);
      repeat (3) step(1, 0);

      // R4 and R2: ON bit alone, T = 512, window 7/8
      tag = "R4"; n_cfg = 0; n_on = 1; n_sel = 1; n_win = 3;
      repeat (1100) step(1, 0);
      tag = "R2"; n_on = 0;
      repeat (5) step(1, 1);
      n_on = 1;
      repeat (5) step(1, 0);

      // R6: finest window, T = 256, opening at 254
      tag = "R6"; n_sel = 0; n_win = 7;
      while (m < 253) step(1, 0);
      tag = "R9"; step(1, 1);
      tag = "R8"; step(1, 1);
      repeat (3) step(1, 0);

      // R7: window code zero
      tag = "R7"; n_win = 0;
      repeat (5) step(1, 0);
      step(1, 1); step(0, 1); step(1, 0);

      // R5: reserved codes act as the largest span
      tag = "R5"; n_sel = 5'd24; n_win = 1;
      repeat (300) step(1, 0);
      step(1, 1);
      n_sel = 5'd31;
      repeat (20) step(1, 0);
      step(1, 1);
      n_sel = 5'd23;
      repeat (5) step(1, 0);

      tag = "R2"; n_cfg = 0; n_on = 0;
      repeat (3) step(0, 0);
      repeat (3) @(posedge clk);
      #6;
      check("R2", "unconsumed predictions", sb.size(), 0);
      finish_run();
   end
endmodule